// File: doc/BRIEF.md
# Programmed-I/O Buffer Ready Flag Tracker

This block keeps the two host-visible availability flags for transfers where software moves every word through a data port itself, without DMA. A start strobe latches the transfer setup: direction, DMA selection, words per block and number of blocks. In a read transfer, the card side reports each full block that has arrived. The block then raises a read-enable flag and emits a one-cycle read-ready interrupt. The flag stays up until software has read the whole block. In a write transfer, the buffer side reports free room for a block. The block then raises a write-enable flag with a write-ready interrupt, and the flag drops once software has written a whole block.

A block counter holds the number of blocks still to be moved. When it reaches zero, neither flag can rise again and no further interrupt is issued. In particular, no write-ready is raised after the final block has been written. Port strobes that arrive while the matching flag is low are dropped and do not advance the count. The buffer storage and the card-side serialiser sit outside the block.

Top module: `pio_buf_flags`

## Requirements
- R1: After reset, rd_en_flag, wr_en_flag, rd_ready_irq and wr_ready_irq are all 0.
- R2: In a read transfer (xfer_dir_rd=1 at start, xfer_dma=0), when rd_en_flag is 0 and blocks remain, a card_blk_ready pulse sets rd_en_flag on the next clock edge. rd_ready_irq is high for exactly that one cycle.
- R3: Once set, rd_en_flag stays 1 until blk_len accepted port_rd strobes have occurred. It drops on the edge that samples the last of them.
- R4: In a write transfer (xfer_dir_rd=0 at start, xfer_dma=0), when wr_en_flag is 0 and blocks remain, a buf_space_free pulse sets wr_en_flag on the next edge. wr_ready_irq is high for exactly that one cycle.
- R5: Once set, wr_en_flag stays 1 until blk_len accepted port_wr strobes have occurred. It drops on the edge that samples the last of them.
- R6: After blk_cnt blocks have completed (immediately, if blk_cnt is 0), no flag and no interrupt rises again until the next start.
- R7: When xfer_dma=1 at start, both flags and both interrupts stay 0 for the whole transfer.
- R8: A port_rd or port_wr strobe made while its matching flag is 0 is ignored. The next block still takes exactly blk_len accepted strobes.
- R9: xfer_start clears both flags and the word count and reloads the block count. It takes priority over every other input in the same cycle.
- R10: The availability strobe of the direction that is not selected never raises a flag.
- R11: An availability strobe while the matching flag is already 1 produces no interrupt and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Latches setup, clears flags and counts |
| xfer_dir_rd | input | 1 | 1 = read transfer, 0 = write transfer (sampled at start) |
| xfer_dma | input | 1 | 1 = DMA transfer, flags unused (sampled at start) |
| blk_len | input | LEN_W | Words per block (sampled at start) |
| blk_cnt | input | CNT_W | Blocks in the transfer (sampled at start) |
| card_blk_ready | input | 1 | A full read block is waiting in the buffer |
| buf_space_free | input | 1 | Room for a full write block |
| port_rd | input | 1 | Data-port read strobe, one word |
| port_wr | input | 1 | Data-port write strobe, one word |
| rd_en_flag | output | 1 | Readable block present |
| wr_en_flag | output | 1 | Writable space present |
| rd_ready_irq | output | 1 | One-cycle pulse on rd_en_flag rise |
| wr_ready_irq | output | 1 | One-cycle pulse on wr_en_flag rise |

## Verification
The hardest state to reach is the end of a transfer. There, an availability strobe arrives after the last block has finished and must produce neither a flag nor an interrupt. Reaching it means walking every block of the transfer through the port, with the exact number of words per block. The bench sweeps every combination of block length 1 to 4, block count 0 to 3, both directions and both DMA settings. In each run it first inserts dropped strobes and wrong-direction availability strobes, then drives one more availability strobe after the final block. A separate sequence restarts a transfer in the middle of a block, with a port strobe in the same cycle as the restart.

// File: rtl/pio_buf_pkg.sv
package pio_buf_pkg;
   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic      dma;
      xfer_dir_e dir;
   } xfer_mode_t;

   localparam int SIDE_RD = 0;
   localparam int SIDE_WR = 1;
   localparam int N_SIDES = 2;
endpackage

// File: rtl/pbf_word_ctr.sv
module pbf_word_ctr #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [LEN_W-1:0] len,
   output logic             last,
   output logic [LEN_W-1:0] count
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   assign last = (count == len - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clr)   count <= '0;
      else if (step)  count <= last ? '0 : count + ONE;
   end

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(count));

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len != '0) |-> (count < len));
endmodule

// File: rtl/pbf_blk_ctr.sv
module pbf_blk_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             any_left
);
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    left <= '0;
      else if (load) left <= load_val;
      else if (dec)  left <= left - CNT_W'(1);
   end

   assign any_left = (left != '0);

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (left != '0));
endmodule

// File: rtl/pbf_side.sv
module pbf_side #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             active,
   input  logic             more_blocks,
   input  logic             avail,
   input  logic             access,
   input  logic [LEN_W-1:0] len,
   output logic             flag,
   output logic             irq,
   output logic             blk_done
);
   logic             take;
   logic             set_req;
   logic             last;
   logic [LEN_W-1:0] wcount;

   assign take     = flag & access & ~clr;
   assign blk_done = take & last;
   assign set_req  = active & more_blocks & avail & ~flag & ~clr;

   pbf_word_ctr #(.LEN_W(LEN_W)) u_words (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (take),
      .len   (len),
      .last  (last),
      .count (wcount)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else if (clr) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else begin
         irq <= set_req;
         if (set_req)       flag <= 1'b1;
         else if (blk_done) flag <= 1'b0;
      end
   end

   // R3
   hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !blk_done && !clr) |=> flag);

   // R8
   idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> (wcount == '0));

   // R11
   irq_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && !$past(flag)));
endmodule

// File: rtl/pio_buf_flags.sv
module pio_buf_flags
   import pio_buf_pkg::*;
#(
   parameter int LEN_W = 12,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic             xfer_dir_rd,
   input  logic             xfer_dma,
   input  logic [LEN_W-1:0] blk_len,
   input  logic [CNT_W-1:0] blk_cnt,
   input  logic             card_blk_ready,
   input  logic             buf_space_free,
   input  logic             port_rd,
   input  logic             port_wr,
   output logic             rd_en_flag,
   output logic             wr_en_flag,
   output logic             rd_ready_irq,
   output logic             wr_ready_irq
);
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("pio_buf_flags: LEN_W must be in 1..16");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pio_buf_flags: CNT_W must be in 1..32");
   end

   xfer_mode_t       mode_q;
   logic [LEN_W-1:0] len_q;
   logic             blocks_left;
   logic [N_SIDES-1:0] avail_v, access_v, active_v;
   logic [N_SIDES-1:0] flag_v, irq_v, done_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '{dma: 1'b1, dir: DIR_WRITE};
         len_q  <= '0;
      end else if (xfer_start) begin
         mode_q <= '{dma: xfer_dma, dir: xfer_dir_e'(xfer_dir_rd)};
         len_q  <= blk_len;
      end
   end

   assign avail_v[SIDE_RD]  = card_blk_ready;
   assign avail_v[SIDE_WR]  = buf_space_free;
   assign access_v[SIDE_RD] = port_rd;
   assign access_v[SIDE_WR] = port_wr;
   assign active_v[SIDE_RD] = !mode_q.dma && (mode_q.dir == DIR_READ);
   assign active_v[SIDE_WR] = !mode_q.dma && (mode_q.dir == DIR_WRITE);

   for (genvar g = 0; g < N_SIDES; g++) begin : g_side
      pbf_side #(.LEN_W(LEN_W)) u_side (
         .clk         (clk),
         .rst_n       (rst_n),
         .clr         (xfer_start),
         .active      (active_v[g]),
         .more_blocks (blocks_left),
         .avail       (avail_v[g]),
         .access      (access_v[g]),
         .len         (len_q),
         .flag        (flag_v[g]),
         .irq         (irq_v[g]),
         .blk_done    (done_v[g])
      );
   end

   pbf_blk_ctr #(.CNT_W(CNT_W)) u_blocks (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (xfer_start),
      .load_val (blk_cnt),
      .dec      (|done_v),
      .any_left (blocks_left)
   );

   assign rd_en_flag   = flag_v[SIDE_RD];
   assign wr_en_flag   = flag_v[SIDE_WR];
   assign rd_ready_irq = irq_v[SIDE_RD];
   assign wr_ready_irq = irq_v[SIDE_WR];

   // R7
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.dma |-> !(rd_en_flag || wr_en_flag || rd_ready_irq || wr_ready_irq));

   // R6
   no_rise_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocks_left && !xfer_start) |=> !(rd_ready_irq || wr_ready_irq));

   // R10
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_v));

   // R9
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !(rd_en_flag || wr_en_flag || rd_ready_irq || wr_ready_irq));
endmodule

// File: tb/pio_buf_flags_tb.sv
module pio_buf_flags_tb;
   localparam int LEN_W = 12;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xfer_start = 0, xfer_dir_rd = 0, xfer_dma = 0;
   logic [LEN_W-1:0] blk_len = '0;
   logic [CNT_W-1:0] blk_cnt = '0;
   logic card_blk_ready = 0, buf_space_free = 0, port_rd = 0, port_wr = 0;
   logic rd_en_flag, wr_en_flag, rd_ready_irq, wr_ready_irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   pio_buf_flags #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir_rd(xfer_dir_rd),
      .xfer_dma(xfer_dma), .blk_len(blk_len), .blk_cnt(blk_cnt),
      .card_blk_ready(card_blk_ready), .buf_space_free(buf_space_free),
      .port_rd(port_rd), .port_wr(port_wr), .rd_en_flag(rd_en_flag),
      .wr_en_flag(wr_en_flag), .rd_ready_irq(rd_ready_irq), .wr_ready_irq(wr_ready_irq)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // selected-side helpers: rd=1 picks read side
   function automatic logic my_flag(input logic rd);
      return rd ? rd_en_flag : wr_en_flag;
   endfunction
   function automatic logic my_irq(input logic rd);
      return rd ? rd_ready_irq : wr_ready_irq;
   endfunction
   function automatic logic other_flag(input logic rd);
      return rd ? wr_en_flag : rd_en_flag;
   endfunction

   task automatic pulse_avail(input logic rd);
      card_blk_ready = rd;
      buf_space_free = !rd;
      cyc();
      card_blk_ready = 0;
      buf_space_free = 0;
   endtask

   task automatic pulse_access(input logic rd);
      port_rd = rd;
      port_wr = !rd;
      cyc();
      port_rd = 0;
      port_wr = 0;
   endtask

   task automatic start(input logic rd, input logic dma, input int len, input int cnt);
      xfer_dir_rd = rd;
      xfer_dma    = dma;
      blk_len     = LEN_W'(len);
      blk_cnt     = CNT_W'(cnt);
      xfer_start  = 1;
      cyc();
      xfer_start  = 0;
   endtask

   task automatic run_cfg(input logic rd, input logic dma, input int len, input int cnt);
      start(rd, dma, len, cnt);
      check("R9 flags clear after start", rd_en_flag | wr_en_flag, 1'b0);
      if (dma) begin
         pulse_avail(1'b1);
         pulse_avail(1'b0);
         pulse_access(rd);
         check("R7 dma flags stay low", rd_en_flag | wr_en_flag, 1'b0);
         check("R7 dma irqs stay low", rd_ready_irq | wr_ready_irq, 1'b0);
         return;
      end
      for (int b = 0; b < cnt; b++) begin
         pulse_access(rd);
         pulse_access(rd);
         check("R8 idle access leaves flag low", my_flag(rd), 1'b0);
         pulse_avail(!rd);
         check("R10 unselected side stays low", other_flag(rd), 1'b0);
         check("R10 selected side untouched", my_flag(rd), 1'b0);
         pulse_avail(rd);
         check(rd ? "R2 read flag rises" : "R4 write flag rises", my_flag(rd), 1'b1);
         check(rd ? "R2 read irq pulse" : "R4 write irq pulse", my_irq(rd), 1'b1);
         pulse_avail(rd);
         check("R11 no irq while flag set", my_irq(rd), 1'b0);
         check("R11 flag stays set", my_flag(rd), 1'b1);
         for (int w = 0; w < len; w++) begin
            pulse_access(rd);
            check(rd ? "R3 read flag vs word count" : "R5 write flag vs word count",
                  my_flag(rd), (w < len - 1) ? 1'b1 : 1'b0);
         end
      end
      pulse_avail(rd);
      check("R6 no flag after last block", my_flag(rd), 1'b0);
      check("R6 no irq after last block", my_irq(rd), 1'b0);
   endtask

   initial begin
      #1;
      check("R1 rd flag reset", rd_en_flag, 1'b0);
      check("R1 wr flag reset", wr_en_flag, 1'b0);
      check("R1 irqs reset", rd_ready_irq | wr_ready_irq, 1'b0);
      cyc();
      rst_n = 1;
      cyc();
      check("R1 flags after reset release", rd_en_flag | wr_en_flag, 1'b0);

      for (int d = 0; d < 2; d++)
         for (int m = 0; m < 2; m++)
            for (int len = 1; len <= 4; len++)
               for (int cnt = 0; cnt <= 3; cnt++)
                  run_cfg(d[0], m[0], len, cnt);

      // R9: restart mid-block, with a read in the same cycle as the start
      start(1'b1, 1'b0, 3, 2);
      pulse_avail(1'b1);
      pulse_access(1'b1);
      check("R9 mid-block flag set", rd_en_flag, 1'b1);
      port_rd = 1;
      start(1'b1, 1'b0, 3, 2);
      port_rd = 0;
      check("R9 start dominates read", rd_en_flag, 1'b0);
      card_blk_ready = 1;
      start(1'b1, 1'b0, 3, 2);
      card_blk_ready = 0;
      check("R9 start dominates avail", rd_en_flag | rd_ready_irq, 1'b0);
      pulse_avail(1'b1);
      check("R9 new block flag", rd_en_flag, 1'b1);
      pulse_access(1'b1);
      pulse_access(1'b1);
      check("R9 word count restarted", rd_en_flag, 1'b1);
      pulse_access(1'b1);
      check("R9 full block after restart", rd_en_flag, 1'b0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule